// File: doc/BRIEF.md
# Thermal Throttle Controller

This block compares a digital die-temperature reading against programmable limits and, when the die runs too hot, asks an external operating-point sequencer to move to a lower, software-chosen frequency/voltage point. It saves the operating point that was active when throttling began. It then holds for a fixed number of cycles and checks the temperature again. If the die has cooled below the trip threshold minus a hysteresis margin, it asks the sequencer to return to the saved point. If the die is still warm, it stays throttled and starts the hold again.

If the sequencer reports that the downward move failed, the block turns on clock-modulation (duty-cycle) throttling as a fallback. That fallback stays on until the return request is issued. A separate over-limit threshold flags a severe out-of-specification temperature. The down move, the up move and the out-of-specification detection each raise a one-cycle interrupt pulse. Each also sets a sticky status bit, which software clears with a write-one-to-clear input.

Top module: `therm_throttle_ctrl`

## Requirements
- R1: After reset, `req_o`, `clkmod_en_o`, `irq_o` and `sticky_o` are all zero.
- R2: When idle and `temp_i` is strictly greater than `trip_thr_i`, `req_o` rises in the next cycle with `req_op_o` equal to `low_op_i`, and `irq_o[0]` (down) pulses in that same cycle. A reading equal to the threshold does not trip.
- R3: The value of `cur_op_i` at the cycle that trips is saved. The later up request carries that saved value, whatever `cur_op_i` does afterwards.
- R4: A request stays asserted with a steady `req_op_o` until `xfer_done_i` or `xfer_fail_i` is seen. After a completed down move, `req_o` stays low for exactly `HOLD_CYCLES` cycles before the temperature is judged.
- R5: At the end of the hold, if `temp_i + hyst_i < trip_thr_i`, `req_o` rises in the next cycle with the saved point, and `irq_o[1]` (up) pulses in that same cycle.
- R6: At the end of the hold, if `temp_i + hyst_i >= trip_thr_i`, no request and no interrupt are raised, and a new hold of `HOLD_CYCLES` cycles begins.
- R7: `xfer_fail_i` during a down request sets `clkmod_en_o` from the next cycle. It stays set through the hold and clears in the cycle in which the up request rises.
- R8: When `temp_i > oos_thr_i` becomes true, `irq_o[2]` pulses for one cycle in the next cycle, whatever the throttle state. It does not pulse again while the condition persists.
- R9: Every `irq_o` bit is a single-cycle pulse and sets the matching `sticky_o` bit in the same cycle. A sticky bit clears only when the matching `clr_i` bit is 1, and a new pulse wins over a clear in the same cycle.
- R10: When an up request is ended by `xfer_done_i` or `xfer_fail_i`, `req_o` falls in the next cycle and the controller can trip again.
- R11: `xfer_done_i` and `xfer_fail_i` have no effect while no request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| temp_i | input | TEMP_W | Die temperature reading |
| trip_thr_i | input | TEMP_W | Throttle trip threshold |
| hyst_i | input | TEMP_W | Hysteresis below trip for the return decision |
| oos_thr_i | input | TEMP_W | Out-of-specification threshold |
| low_op_i | input | OP_W | Programmed throttled operating point |
| cur_op_i | input | OP_W | Operating point currently in effect |
| xfer_done_i | input | 1 | Sequencer finished the requested move |
| xfer_fail_i | input | 1 | Sequencer could not complete the requested move |
| clr_i | input | 3 | Write-one-to-clear for sticky bits |
| req_o | output | 1 | Operating-point change request |
| req_op_o | output | OP_W | Requested operating point |
| clkmod_en_o | output | 1 | Clock-modulation fallback enable |
| irq_o | output | 3 | Interrupt pulses: bit0 down, bit1 up, bit2 out-of-spec |
| sticky_o | output | 3 | Latched interrupt status, same bit order |

## Verification
A wrong saved operating point shows up only at the end of a throttle episode, as a bad `req_op_o` on the up request. For that reason the bench changes `cur_op_i` while throttled and compares the return value. An off-by-one in the hold counter moves the up request by one cycle, so the bench checks `req_o` in the cycle before the hold ends as well as in the cycle it ends. A state machine that leaks between states shows up at once as a request or interrupt pulse on stray `xfer_done_i` or `xfer_fail_i` inputs. A fallback flag that is never cleared stays visible on `clkmod_en_o` after the up request.

// File: rtl/thr_pkg.sv
package thr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DOWN = 2'd1,
    ST_HOLD = 2'd2,
    ST_UP   = 2'd3
  } thr_state_e;

  localparam int IRQ_N    = 3;
  localparam int IRQ_DOWN = 0;
  localparam int IRQ_UP   = 1;
  localparam int IRQ_OOS  = 2;
endpackage

// File: rtl/thr_compare.sv
module thr_compare #(
  parameter int TEMP_W = 8
) (
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] trip_thr_i,
  input  logic [TEMP_W-1:0] hyst_i,
  input  logic [TEMP_W-1:0] oos_thr_i,
  output logic              hot_o,
  output logic              cool_o,
  output logic              oos_hot_o
);
  localparam int SUM_W = TEMP_W + 1;

  logic [SUM_W-1:0] temp_plus_hyst;

  // widened sum avoids wrap when hysteresis is large
  assign temp_plus_hyst = {1'b0, temp_i} + {1'b0, hyst_i};
  assign hot_o     = temp_i > trip_thr_i;
  assign cool_o    = temp_plus_hyst < {1'b0, trip_thr_i};
  assign oos_hot_o = temp_i > oos_thr_i;
endmodule

// File: rtl/thr_hold_timer.sv
module thr_hold_timer #(
  parameter int HOLD_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= LOAD_V;
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/thr_fsm.sv
module thr_fsm
  import thr_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hot_i,
  input  logic            cool_i,
  input  logic            expired_i,
  input  logic [OP_W-1:0] low_op_i,
  input  logic [OP_W-1:0] cur_op_i,
  input  logic            xfer_done_i,
  input  logic            xfer_fail_i,
  output logic            req_o,
  output logic [OP_W-1:0] req_op_o,
  output logic            clkmod_en_o,
  output logic            ev_down_o,
  output logic            ev_up_o,
  output logic            tmr_load_o,
  output logic            tmr_run_o
);
  thr_state_e      state_q, state_d;
  logic [OP_W-1:0] saved_op_q;
  logic [OP_W-1:0] req_op_q;
  logic            clkmod_q;
  logic            xfer_end;

  assign xfer_end  = xfer_done_i || xfer_fail_i;
  assign ev_down_o = (state_q == ST_IDLE) && hot_i;
  assign ev_up_o   = (state_q == ST_HOLD) && expired_i && cool_i;
  assign tmr_run_o = (state_q == ST_HOLD);
  assign tmr_load_o = ((state_q == ST_DOWN) && xfer_end) ||
                      ((state_q == ST_HOLD) && expired_i && !cool_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (hot_i) state_d = ST_DOWN;
      ST_DOWN: if (xfer_end) state_d = ST_HOLD;
      ST_HOLD: if (expired_i && cool_i) state_d = ST_UP;
      ST_UP:   if (xfer_end) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      saved_op_q <= '0;
      req_op_q   <= '0;
      clkmod_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_down_o) begin
        saved_op_q <= cur_op_i;
        req_op_q   <= low_op_i;
      end
      if (ev_up_o) begin
        req_op_q <= saved_op_q;
        clkmod_q <= 1'b0;
      end else if ((state_q == ST_DOWN) && xfer_fail_i) begin
        clkmod_q <= 1'b1;
      end
    end
  end

  assign req_o       = (state_q == ST_DOWN) || (state_q == ST_UP);
  assign req_op_o    = req_op_q;
  assign clkmod_en_o = clkmod_q;
endmodule

// File: rtl/thr_irq.sv
module thr_irq #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pulse_o,
  output logic [N-1:0] sticky_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    logic pulse_q, sticky_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pulse_q  <= 1'b0;
        sticky_q <= 1'b0;
      end else begin
        pulse_q <= ev_i[g];
        if (ev_i[g])      sticky_q <= 1'b1;
        else if (clr_i[g]) sticky_q <= 1'b0;
      end
    end
    assign pulse_o[g]  = pulse_q;
    assign sticky_o[g] = sticky_q;
  end
endmodule

// File: rtl/therm_throttle_ctrl.sv
module therm_throttle_ctrl
  import thr_pkg::*;
#(
  parameter int TEMP_W      = 8,
  parameter int OP_W        = 4,
  parameter int HOLD_CYCLES = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] trip_thr_i,
  input  logic [TEMP_W-1:0] hyst_i,
  input  logic [TEMP_W-1:0] oos_thr_i,
  input  logic [OP_W-1:0]   low_op_i,
  input  logic [OP_W-1:0]   cur_op_i,
  input  logic              xfer_done_i,
  input  logic              xfer_fail_i,
  input  logic [2:0]        clr_i,
  output logic              req_o,
  output logic [OP_W-1:0]   req_op_o,
  output logic              clkmod_en_o,
  output logic [2:0]        irq_o,
  output logic [2:0]        sticky_o
);
  logic hot, cool, oos_hot, oos_hot_q;
  logic expired, tmr_load, tmr_run;
  logic ev_down, ev_up;
  logic [IRQ_N-1:0] ev;

  thr_compare #(.TEMP_W(TEMP_W)) u_cmp (
    .temp_i    (temp_i),
    .trip_thr_i(trip_thr_i),
    .hyst_i    (hyst_i),
    .oos_thr_i (oos_thr_i),
    .hot_o     (hot),
    .cool_o    (cool),
    .oos_hot_o (oos_hot)
  );

  thr_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .run_i    (tmr_run),
    .expired_o(expired)
  );

  thr_fsm #(.OP_W(OP_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hot_i      (hot),
    .cool_i     (cool),
    .expired_i  (expired),
    .low_op_i   (low_op_i),
    .cur_op_i   (cur_op_i),
    .xfer_done_i(xfer_done_i),
    .xfer_fail_i(xfer_fail_i),
    .req_o      (req_o),
    .req_op_o   (req_op_o),
    .clkmod_en_o(clkmod_en_o),
    .ev_down_o  (ev_down),
    .ev_up_o    (ev_up),
    .tmr_load_o (tmr_load),
    .tmr_run_o  (tmr_run)
  );

  // out-of-spec fires on the rising edge of the over-limit condition
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oos_hot_q <= 1'b0;
    else         oos_hot_q <= oos_hot;
  end

  always_comb begin
    ev           = '0;
    ev[IRQ_DOWN] = ev_down;
    ev[IRQ_UP]   = ev_up;
    ev[IRQ_OOS]  = oos_hot && !oos_hot_q;
  end

  thr_irq #(.N(IRQ_N)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev),
    .clr_i   (clr_i),
    .pulse_o (irq_o),
    .sticky_o(sticky_o)
  );
endmodule

// File: rtl/thr_checker.sv
module thr_checker #(
  parameter int TEMP_W = 8,
  parameter int OP_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [TEMP_W-1:0] temp_i,
  input logic [TEMP_W-1:0] oos_thr_i,
  input logic              xfer_done_i,
  input logic              xfer_fail_i,
  input logic              req_o,
  input logic [OP_W-1:0]   req_op_o,
  input logic              clkmod_en_o,
  input logic [2:0]        irq_o,
  input logic [2:0]        sticky_o
);
  assert_req_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !xfer_done_i && !xfer_fail_i) |=> (req_o && $stable(req_op_o)));

  assert_req_rise_irq_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> (irq_o[0] || irq_o[1]));

  assert_down_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[0] |=> !irq_o[0]);

  assert_sticky_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != 3'b000) |-> ((sticky_o & irq_o) == irq_o));

  assert_fallback_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clkmod_en_o) |-> $past(xfer_fail_i));

  assert_oos_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[2] |-> ($past(temp_i) > $past(oos_thr_i)));
endmodule

bind therm_throttle_ctrl thr_checker #(.TEMP_W(TEMP_W), .OP_W(OP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .temp_i     (temp_i),
  .oos_thr_i  (oos_thr_i),
  .xfer_done_i(xfer_done_i),
  .xfer_fail_i(xfer_fail_i),
  .req_o      (req_o),
  .req_op_o   (req_op_o),
  .clkmod_en_o(clkmod_en_o),
  .irq_o      (irq_o),
  .sticky_o   (sticky_o)
);

// File: tb/therm_throttle_ctrl_test.sv
`timescale 1ns/1ps
module therm_throttle_ctrl_test;
  localparam int TEMP_W = 8;
  localparam int OP_W   = 4;
  localparam int HOLD   = 6;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [TEMP_W-1:0] temp = '0, trip = 8'd80, hyst = 8'd5, oos = 8'd100;
  logic [OP_W-1:0]   low_op = 4'd2, cur_op = 4'd9;
  logic              done = 1'b0, fail = 1'b0;
  logic [2:0]        clr = '0;
  logic              req, clkmod;
  logic [OP_W-1:0]   req_op;
  logic [2:0]        irq, sticky;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  therm_throttle_ctrl #(.TEMP_W(TEMP_W), .OP_W(OP_W), .HOLD_CYCLES(HOLD)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .temp_i(temp), .trip_thr_i(trip),
    .hyst_i(hyst), .oos_thr_i(oos), .low_op_i(low_op), .cur_op_i(cur_op),
    .xfer_done_i(done), .xfer_fail_i(fail), .clr_i(clr),
    .req_o(req), .req_op_o(req_op), .clkmod_en_o(clkmod),
    .irq_o(irq), .sticky_o(sticky)
  );

  // temp, trip, oos threshold, expected req, expected oos pulse
  typedef struct packed {
    logic [7:0] t; logic [7:0] tr; logic [7:0] o; logic er; logic eo;
  } vec_t;
  localparam vec_t VECS [8] = '{
    '{8'd80,  8'd80,  8'd200, 1'b0, 1'b0},
    '{8'd81,  8'd80,  8'd200, 1'b1, 1'b0},
    '{8'd0,   8'd0,   8'd255, 1'b0, 1'b0},
    '{8'd255, 8'd254, 8'd255, 1'b1, 1'b0},
    '{8'd201, 8'd255, 8'd200, 1'b0, 1'b1},
    '{8'd200, 8'd199, 8'd200, 1'b1, 1'b0},
    '{8'd10,  8'd9,   8'd9,   1'b1, 1'b1},
    '{8'd255, 8'd255, 8'd255, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    done = 0; fail = 0; clr = '0;
    step();
    rst_ni = 1'b1;
    step();
  endtask

  initial begin
    @(negedge clk);
    temp = 8'd50;
    do_reset();
    chk("R1 req", req, 0);
    chk("R1 clkmod", clkmod, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sticky", sticky, 0);

    // table walk: trip and out-of-spec decisions at their boundaries
    foreach (VECS[i]) begin
      temp = 8'd0; trip = VECS[i].tr; oos = VECS[i].o;
      do_reset();
      temp = VECS[i].t;
      step();
      chk("R2 table req", req, VECS[i].er);
      chk("R8 table oos", irq[2], VECS[i].eo);
    end

    // directed throttle episode
    trip = 8'd80; hyst = 8'd5; oos = 8'd100; low_op = 4'd2; cur_op = 4'd9;
    temp = 8'd50;
    do_reset();
    step();
    chk("R2 no trip below", req, 0);
    temp = 8'd81;
    step();
    chk("R2 req", req, 1);
    chk("R2 req_op low", req_op, 4'd2);
    chk("R2 down irq", irq, 3'b001);
    chk("R9 sticky down", sticky, 3'b001);
    cur_op = 4'd3;
    step();
    chk("R4 req held", req, 1);
    chk("R9 pulse one cycle", irq, 3'b000);
    done = 1;
    step();
    done = 0;
    chk("R4 req low in hold", req, 0);
    temp = 8'd76;  // 76+5 = 81, not cool
    for (int k = 0; k < HOLD; k++) step();
    chk("R6 no up when warm", req, 0);
    chk("R6 no irq when warm", irq, 3'b000);
    temp = 8'd74;  // 74+5 = 79, cool
    for (int k = 0; k < HOLD - 1; k++) step();
    chk("R6 hold restarted", req, 0);
    step();
    chk("R5 up req", req, 1);
    chk("R3 saved op", req_op, 4'd9);
    chk("R5 up irq", irq, 3'b010);
    done = 1;
    step();
    done = 0;
    chk("R10 req falls", req, 0);
    step();
    chk("R10 idle stays", req, 0);

    clr = 3'b011;
    step();
    clr = 3'b000;
    chk("R9 sticky cleared", sticky, 3'b000);

    // R11: stray completion flags while idle
    done = 1; fail = 1;
    step();
    done = 0; fail = 0;
    chk("R11 no req", req, 0);
    chk("R11 no irq", irq, 3'b000);
    chk("R11 no clkmod", clkmod, 0);

    // second episode: oos with simultaneous clear, then failed move
    cur_op = 4'd3;
    temp = 8'd101;
    clr = 3'b100;
    step();
    clr = 3'b000;
    chk("R8 oos pulse", irq, 3'b101);
    chk("R9 set beats clear", sticky[2], 1);
    step();
    chk("R8 no repeat", irq[2], 0);
    chk("R2 still requesting", req, 1);
    fail = 1;
    step();
    fail = 0;
    chk("R7 clkmod set", clkmod, 1);
    chk("R7 req dropped", req, 0);
    temp = 8'd50;
    for (int k = 0; k < HOLD - 1; k++) step();
    chk("R7 clkmod held", clkmod, 1);
    step();
    chk("R7 clkmod cleared on up", clkmod, 0);
    chk("R5 up req after fail", req, 1);
    chk("R3 saved op second", req_op, 4'd3);
    fail = 1;
    step();
    fail = 0;
    chk("R10 up fail ends", req, 0);
    temp = 8'd90;
    step();
    chk("R10 can trip again", req, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule